// File: doc/BRIEF.md
# Packet Row Buffer with Host Read Pointer

This block is the storage stage between a video-line data slicer and a host processor. The slicer hands over each received line as a fixed-length packet of `ROW_BYTES` bytes (44 by default): two information bytes for the line/field and the data type, two magazine/row-address bytes, then 40 payload bytes. The block places each packet in its own row of a byte RAM of `MEM_BYTES` bytes (2048 by default). Row 0, byte addresses 0 to `ROW_BYTES-1`, is kept back for control information, so packet rows begin at byte address `ROW_BYTES`. The default geometry gives 45 packet rows, used as a circular queue.

The host sees a single 8-bit read port. An internal byte pointer supplies each read and then moves forward, so bytes come out in the order they were received. A two-bit command input can restart the buffer, rewind the pointer to the first byte of the packet being read, or skip to the first byte of the next packet. The block reports how many whole packets can be read, and it raises a sticky flag when a packet has to be discarded because every row is occupied.

The write side is a valid/ready byte stream. `in_ready` is always high, so the source never sees back-pressure. A packet that arrives while the buffer is full is accepted and discarded, and `overflow` records the loss.

Top module: `pkt_row_buffer`

## Requirements
- R1: After reset, `rd_addr` equals `ROW_BYTES` (the first byte of packet row 0), `pkt_count` is 0, `overflow` is 0 and `rd_data` is 0x00. `rd_addr` never points into the reserved row 0 and never points past the last row.
- R2: `in_ready` is always 1. Every `ROW_BYTES` accepted bytes form one packet, stored in arrival order. `pkt_count` rises by one in the cycle after the last byte of a packet is accepted, and not before.
- R3: If a packet's first byte is accepted while `pkt_count` equals the number of packet rows, the whole packet is discarded and `overflow` goes to 1. `overflow` stays at 1 until a restart command or a reset. `pkt_count` never exceeds the number of packet rows.
- R4: A read (`rd_en`=1, `cmd`=00, `pkt_count`>0) puts the byte at `rd_addr` on `rd_data` in the next cycle and advances `rd_addr` by one. `rd_data` holds its value in cycles without `rd_en`.
- R5: A read of the last byte of a row moves `rd_addr` to the first byte of the next row and lowers `pkt_count` by one.
- R6: Both the write side and the read side wrap from the last packet row back to packet row 0 at byte address `ROW_BYTES`.
- R7: A read while `pkt_count` is 0 returns 0x00 and leaves `rd_addr` unchanged.
- R8: Command 01 (restart) sets `rd_addr` to `ROW_BYTES`, clears `pkt_count` and `overflow`, and makes the next packet go to row 0. A packet that is partly written at that moment is abandoned and its remaining bytes are discarded.
- R9: Command 10 (rewind) sets `rd_addr` to the first byte of the current row and leaves `pkt_count` unchanged.
- R10: Command 11 (skip) moves `rd_addr` to the first byte of the next row from any byte offset and lowers `pkt_count` by one. When `pkt_count` is 0, skip has no effect.
- R11: A read requested in the same cycle as a nonzero command is ignored: `rd_data` becomes 0x00 and only the command acts on the pointer.
- R12: When a packet completes in the same cycle that a read finishes a packet, `pkt_count` is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Packet byte offered by the front end |
| in_ready | output | 1 | Byte accepted; constant 1 |
| in_data | input | 8 | Packet byte |
| cmd | input | 2 | Pointer command: 00 none, 01 restart, 10 rewind, 11 skip |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 8 | Byte returned by the last read, one cycle after `rd_en` |
| rd_addr | output | $clog2(MEM_BYTES) | Absolute byte address of the next read |
| pkt_count | output | $clog2(packet rows + 1) | Number of complete packets not yet consumed |
| overflow | output | 1 | Sticky flag: a packet was discarded because the buffer was full |

## Verification
Every result is due one clock edge after the stimulus that causes it. `rd_data` after a read strobe, `rd_addr` after a read or a command, `pkt_count` after the last byte of a packet or after the consuming read, and `overflow` after the first byte of a dropped packet all appear after that single edge. The bench drives inputs on the falling edge and compares outputs on the next falling edge, so each value is checked half a cycle after the rising edge that produced it. The expected byte values, addresses and counts come from a small arithmetic model of rows, offsets and packet identities. The bench exercises all fill levels from empty to one past full, at every starting row of a reduced geometry.

// File: rtl/pkt_buf_pkg.sv
package pkt_buf_pkg;
  typedef enum logic [1:0] {
    CMD_NONE    = 2'b00,
    CMD_RESTART = 2'b01,
    CMD_REWIND  = 2'b10,
    CMD_SKIP    = 2'b11
  } ptr_cmd_e;
endpackage

// File: rtl/pkt_ram.sv
module pkt_ram #(
  parameter int DEPTH = 1980,
  parameter int AW    = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pkt_wr_alloc.sv
module pkt_wr_alloc #(
  parameter int ROW_BYTES = 44,
  parameter int PKT_ROWS  = 45,
  parameter int OFS_W     = 6,
  parameter int ROW_W     = 6,
  parameter int CNT_W     = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_fire,
  input  logic             restart,
  input  logic [CNT_W-1:0] count,
  output logic             we,
  output logic             commit,
  output logic [ROW_W-1:0] row,
  output logic [OFS_W-1:0] ofs,
  output logic             overflow
);
  logic [OFS_W-1:0] ofs_q, ofs_nxt;
  logic [ROW_W-1:0] row_q, row_nxt;
  logic             drop_q, ovf_q;
  logic             at_start, at_end, full, drop_cur;

  always_comb begin
    at_start = (ofs_q == '0);
    at_end   = (ofs_q == OFS_W'(ROW_BYTES - 1));
    full     = (count == CNT_W'(PKT_ROWS));
    drop_cur = at_start ? full : drop_q;
    ofs_nxt  = at_end ? '0 : ofs_q + OFS_W'(1);
    row_nxt  = (row_q == ROW_W'(PKT_ROWS - 1)) ? '0 : row_q + ROW_W'(1);
    we       = in_fire && !drop_cur && !restart;
    commit   = we && at_end;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ofs_q  <= '0;
      row_q  <= '0;
      drop_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (in_fire) ofs_q <= ofs_nxt;
      if (restart) begin
        row_q  <= '0;
        ovf_q  <= 1'b0;
        drop_q <= in_fire ? (ofs_nxt != '0) : (ofs_q != '0);
      end else begin
        if (in_fire && at_start) begin
          drop_q <= full;
          if (full) ovf_q <= 1'b1;
        end
        if (commit) row_q <= row_nxt;
      end
    end
  end

  assign row      = row_q;
  assign ofs      = ofs_q;
  assign overflow = ovf_q;
endmodule

// File: rtl/pkt_rd_ptr.sv
module pkt_rd_ptr
  import pkt_buf_pkg::*;
#(
  parameter int ROW_BYTES = 44,
  parameter int PKT_ROWS  = 45,
  parameter int OFS_W     = 6,
  parameter int ROW_W     = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  ptr_cmd_e         cmd,
  input  logic             has_pkt,
  output logic             rd_ok,
  output logic             consume,
  output logic [ROW_W-1:0] row,
  output logic [OFS_W-1:0] ofs
);
  logic [ROW_W-1:0] row_q, row_nxt;
  logic [OFS_W-1:0] ofs_q;
  logic             at_end;

  always_comb begin
    at_end  = (ofs_q == OFS_W'(ROW_BYTES - 1));
    row_nxt = (row_q == ROW_W'(PKT_ROWS - 1)) ? '0 : row_q + ROW_W'(1);
    rd_ok   = rd_en && (cmd == CMD_NONE) && has_pkt;
    consume = ((cmd == CMD_SKIP) && has_pkt) || (rd_ok && at_end);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q <= '0;
      ofs_q <= '0;
    end else begin
      unique case (cmd)
        CMD_RESTART: begin
          row_q <= '0;
          ofs_q <= '0;
        end
        CMD_REWIND: ofs_q <= '0;
        CMD_SKIP: if (has_pkt) begin
          row_q <= row_nxt;
          ofs_q <= '0;
        end
        default: if (rd_ok) begin
          if (at_end) begin
            row_q <= row_nxt;
            ofs_q <= '0;
          end else begin
            ofs_q <= ofs_q + OFS_W'(1);
          end
        end
      endcase
    end
  end

  assign row = row_q;
  assign ofs = ofs_q;
endmodule

// File: rtl/pkt_occupancy.sv
module pkt_occupancy #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             commit,
  input  logic             consume,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      count_q <= '0;
    end else begin
      unique case ({commit, consume})
        2'b10:   count_q <= count_q + CNT_W'(1);
        2'b01:   count_q <= count_q - CNT_W'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  assign count = count_q;
endmodule

// File: rtl/pkt_row_buffer.sv
module pkt_row_buffer
  import pkt_buf_pkg::*;
#(
  parameter int ROW_BYTES = 44,
  parameter int MEM_BYTES = 2048,
  localparam int ROWS_TOTAL = MEM_BYTES / ROW_BYTES,
  localparam int PKT_ROWS   = ROWS_TOTAL - 1,
  localparam int ADDR_W     = $clog2(MEM_BYTES),
  localparam int CNT_W      = $clog2(PKT_ROWS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic [1:0]        cmd,
  input  logic              rd_en,
  output logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  pkt_count,
  output logic              overflow
);
  localparam int RAM_DEPTH = PKT_ROWS * ROW_BYTES;
  localparam int RAM_AW    = $clog2(RAM_DEPTH);
  localparam int OFS_W     = (ROW_BYTES > 1) ? $clog2(ROW_BYTES) : 1;
  localparam int ROW_W     = (PKT_ROWS > 1) ? $clog2(PKT_ROWS) : 1;

  ptr_cmd_e          cmd_e;
  logic              restart, in_fire;
  logic              wr_we, wr_commit;
  logic [ROW_W-1:0]  wr_row, rd_row;
  logic [OFS_W-1:0]  wr_ofs, rd_ofs;
  logic              rd_ok, consume;
  logic [CNT_W-1:0]  count;
  logic [RAM_AW-1:0] ram_waddr, ram_raddr;
  logic [7:0]        ram_q;
  logic              zero_q;

  assign cmd_e    = ptr_cmd_e'(cmd);
  assign restart  = (cmd_e == CMD_RESTART);
  assign in_ready = 1'b1;
  assign in_fire  = in_valid && in_ready;

  pkt_wr_alloc #(
    .ROW_BYTES(ROW_BYTES), .PKT_ROWS(PKT_ROWS),
    .OFS_W(OFS_W), .ROW_W(ROW_W), .CNT_W(CNT_W)
  ) u_wr (
    .clk(clk), .rst(rst), .in_fire(in_fire), .restart(restart),
    .count(count), .we(wr_we), .commit(wr_commit),
    .row(wr_row), .ofs(wr_ofs), .overflow(overflow)
  );

  pkt_rd_ptr #(
    .ROW_BYTES(ROW_BYTES), .PKT_ROWS(PKT_ROWS),
    .OFS_W(OFS_W), .ROW_W(ROW_W)
  ) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .cmd(cmd_e),
    .has_pkt(count != '0), .rd_ok(rd_ok), .consume(consume),
    .row(rd_row), .ofs(rd_ofs)
  );

  pkt_occupancy #(.CNT_W(CNT_W)) u_occ (
    .clk(clk), .rst(rst), .restart(restart),
    .commit(wr_commit), .consume(consume), .count(count)
  );

  assign ram_waddr = RAM_AW'(wr_row) * RAM_AW'(ROW_BYTES) + RAM_AW'(wr_ofs);
  assign ram_raddr = RAM_AW'(rd_row) * RAM_AW'(ROW_BYTES) + RAM_AW'(rd_ofs);

  pkt_ram #(.DEPTH(RAM_DEPTH), .AW(RAM_AW)) u_ram (
    .clk(clk), .we(wr_we), .waddr(ram_waddr), .wdata(in_data),
    .re(rd_ok), .raddr(ram_raddr), .rdata(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst)        zero_q <= 1'b1;
    else if (rd_en) zero_q <= !rd_ok;
  end

  assign rd_data   = zero_q ? 8'h00 : ram_q;
  assign rd_addr   = ADDR_W'(ROW_BYTES) + ADDR_W'(rd_row) * ADDR_W'(ROW_BYTES) + ADDR_W'(rd_ofs);
  assign pkt_count = count;
endmodule

// File: rtl/pkt_row_buffer_chk.sv
module pkt_row_buffer_chk #(
  parameter int ROW_BYTES = 44,
  parameter int MEM_BYTES = 2048,
  localparam int ROWS_TOTAL = MEM_BYTES / ROW_BYTES,
  localparam int PKT_ROWS   = ROWS_TOTAL - 1,
  localparam int ADDR_W     = $clog2(MEM_BYTES),
  localparam int CNT_W      = $clog2(PKT_ROWS + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [1:0]        cmd,
  input logic              rd_en,
  input logic [7:0]        rd_data,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [CNT_W-1:0]  pkt_count,
  input logic              overflow
);
  a_r1_ptr_in_rows: assert property (@(posedge clk) disable iff (rst)
    (int'(rd_addr) >= ROW_BYTES) && (int'(rd_addr) < ROW_BYTES * ROWS_TOTAL));

  a_r2_always_ready: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> in_ready);

  a_r3_count_cap: assert property (@(posedge clk) disable iff (rst)
    int'(pkt_count) <= PKT_ROWS);

  a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (overflow && (cmd != 2'b01)) |=> overflow);

  a_r7_empty_read: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (cmd == 2'b00) && (pkt_count == '0)) |=> ((rd_data == 8'h00) && $stable(rd_addr)));

  a_r8_restart: assert property (@(posedge clk) disable iff (rst)
    (cmd == 2'b01) |=> ((pkt_count == '0) && (int'(rd_addr) == ROW_BYTES) && !overflow));

  a_r9_rewind: assert property (@(posedge clk) disable iff (rst)
    (cmd == 2'b10) |=> ((((int'(rd_addr) - ROW_BYTES) % ROW_BYTES) == 0)
                        && (int'(rd_addr) <= int'($past(rd_addr)))
                        && (int'(rd_addr) + ROW_BYTES > int'($past(rd_addr)))));

  a_r10_skip_row_start: assert property (@(posedge clk) disable iff (rst)
    ((cmd == 2'b11) && (pkt_count != '0)) |=> (((int'(rd_addr) - ROW_BYTES) % ROW_BYTES) == 0));

  a_r11_cmd_read_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (cmd != 2'b00)) |=> (rd_data == 8'h00));

  a_r12_count_step: assert property (@(posedge clk) disable iff (rst)
    (cmd != 2'b01) |=> ((int'(pkt_count) <= int'($past(pkt_count)) + 1)
                        && (int'(pkt_count) + 1 >= int'($past(pkt_count)))));
endmodule

bind pkt_row_buffer pkt_row_buffer_chk #(.ROW_BYTES(ROW_BYTES), .MEM_BYTES(MEM_BYTES)) u_chk (.*);

// File: tb/tb_pkt_row_buffer.sv
module tb_pkt_row_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int RB = 8;
  localparam int MB = 40;
  localparam int PR = MB / RB - 1;
  localparam int AW = $clog2(MB);
  localparam int CW = $clog2(PR + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [7:0]    in_data = 8'h00;
  logic [1:0]    cmd = 2'b00;
  logic          rd_en = 1'b0;
  logic [7:0]    rd_data;
  logic [AW-1:0] rd_addr;
  logic [CW-1:0] pkt_count;
  logic          overflow;

  int n_chk = 0;
  int n_fail = 0;
  int m_head = 0, m_ofs = 0, m_count = 0, m_wrow = 0, m_ovf = 0;
  int row_id [PR];
  int next_id = 1;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pkt_row_buffer #(.ROW_BYTES(RB), .MEM_BYTES(MB)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .cmd(cmd), .rd_en(rd_en), .rd_data(rd_data),
    .rd_addr(rd_addr), .pkt_count(pkt_count), .overflow(overflow)
  );

  function automatic int pat(input int id, input int i);
    return (id * 37 + i * 5 + 3) & 255;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    chk(req, int'(rd_addr), (1 + m_head) * RB + m_ofs);
    chk(req, int'(pkt_count), m_count);
    chk(req, int'(overflow), m_ovf);
  endtask

  task automatic push_pkt(input int id);
    bit drop;
    drop = (m_count == PR);
    for (int i = 0; i < RB; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = 8'(pat(id, i));
    end
    @(negedge clk);
    in_valid = 1'b0;
    if (drop) m_ovf = 1;
    else begin
      row_id[m_wrow] = id;
      m_wrow = (m_wrow + 1) % PR;
      m_count++;
    end
    chk("R2 R3 R6 push", int'(pkt_count), m_count);
    chk("R3 overflow", int'(overflow), m_ovf);
  endtask

  task automatic read_byte();
    int exp;
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    if (m_count == 0) begin
      chk("R7 empty read data", int'(rd_data), 0);
    end else begin
      exp = pat(row_id[m_head], m_ofs);
      chk("R4 read data", int'(rd_data), exp);
      m_ofs++;
      if (m_ofs == RB) begin
        m_ofs = 0;
        m_head = (m_head + 1) % PR;
        m_count--;
      end
    end
    chk_state("R4 R5 R6 R7 pointer");
  endtask

  task automatic do_cmd(input logic [1:0] c, input bit with_rd);
    @(negedge clk);
    cmd = c;
    rd_en = with_rd;
    @(negedge clk);
    cmd = 2'b00;
    rd_en = 1'b0;
    case (c)
      2'b01: begin m_head = 0; m_ofs = 0; m_count = 0; m_wrow = 0; m_ovf = 0; end
      2'b10: m_ofs = 0;
      2'b11: if (m_count > 0) begin
        m_head = (m_head + 1) % PR; m_ofs = 0; m_count--;
      end
      default: ;
    endcase
    if (with_rd) chk("R11 read during command", int'(rd_data), 0);
    chk_state("R8 R9 R10 command");
  endtask

  task automatic drain();
    while (m_count > 0) read_byte();
    read_byte();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset addr", int'(rd_addr), RB);
    chk("R1 reset count", int'(pkt_count), 0);
    chk("R1 reset overflow", int'(overflow), 0);
    chk("R1 reset data", int'(rd_data), 0);
    chk("R2 ready", int'(in_ready), 1);

    // R7 empty read
    read_byte();

    // R2 R4 R5 single packet
    push_pkt(next_id++);
    drain();

    // R6 R3 fill with wrap, then overflow
    for (int k = 0; k < PR; k++) push_pkt(next_id++);
    push_pkt(next_id++);
    drain();
    chk("R3 sticky", int'(overflow), 1);

    // R9 rewind mid packet, R10 skip mid packet and on empty
    push_pkt(next_id++);
    push_pkt(next_id++);
    repeat (3) read_byte();
    do_cmd(2'b10, 1'b0);
    repeat (2) read_byte();
    do_cmd(2'b11, 1'b0);
    repeat (RB) read_byte();
    do_cmd(2'b11, 1'b0);
    read_byte();

    // R11 read in a command cycle
    push_pkt(next_id++);
    repeat (2) read_byte();
    do_cmd(2'b10, 1'b1);
    do_cmd(2'b00, 1'b0);
    drain();

    // R8 restart clears overflow and returns to row 0
    do_cmd(2'b01, 1'b0);
    push_pkt(next_id++);
    drain();

    // R12 commit and consume in the same cycle
    do_cmd(2'b01, 1'b0);
    push_pkt(next_id);
    repeat (RB - 1) read_byte();
    for (int i = 0; i < RB - 1; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data = 8'(pat(next_id + 1, i));
    end
    @(negedge clk);
    in_data = 8'(pat(next_id + 1, RB - 1));
    rd_en = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rd_en = 1'b0;
    chk("R12 data", int'(rd_data), pat(next_id, RB - 1));
    row_id[m_wrow] = next_id + 1;
    m_wrow = (m_wrow + 1) % PR;
    m_ofs = 0;
    m_head = (m_head + 1) % PR;
    chk_state("R12 count unchanged");
    next_id += 2;
    drain();

    // R8 restart abandons a partly written packet
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data = 8'(i);
    end
    @(negedge clk);
    in_valid = 1'b0;
    do_cmd(2'b01, 1'b0);
    for (int i = 3; i < RB; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data = 8'(i);
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 abandoned packet", int'(pkt_count), 0);
    push_pkt(next_id++);
    drain();

    // sweep: every starting row, every fill level up to one past full
    for (int s = 0; s < PR; s++) begin
      for (int n = 0; n <= PR + 1; n++) begin
        do_cmd(2'b01, 1'b0);
        for (int k = 0; k < s; k++) push_pkt(next_id++);
        drain();
        for (int k = 0; k < n; k++) push_pkt(next_id++);
        drain();
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule